// File: doc/BRIEF.md
# Raster Screen Fill Controller

This block produces the write stream that paints a whole 160 by 120 frame. After a start pulse it visits every pixel once, one pixel per clock. It drives the pixel coordinates, a 3-bit colour and a plot strobe to an external frame-buffer or display adapter. The scan goes row by row. Within a row the column advances every cycle, and the row advances when the column wraps. Each pixel's colour is the low three bits of its column, so the finished frame shows vertical stripes that repeat every eight columns.

The block is split into a controller and a datapath. The controller is a three-state machine (idle, running, finished). The datapath holds the registered column and row counters and detects the end of the frame. The two are joined by clear, increment and end-of-frame signals. A finished indication stays high until the next start. A start that arrives while a fill is running has no effect.

Top module: `screen_fill_top`

## Requirements
- R1: A synchronous active-high reset, applied at any time, forces plot low, done low, x to 0 and y to 0 from the next clock edge.
- R2: A start sampled high while idle or finished gives plot high with x=0 and y=0 on the next cycle.
- R3: During a fill, while x is below 159, each cycle increments x by one and leaves y unchanged.
- R4: During a fill, a cycle with x=159 and y below 119 is followed by x=0 and y incremented by one.
- R5: Whenever plot is high, the colour output equals x modulo 8, which is bits 2:0 of x.
- R6: A fill issues exactly 19,200 consecutive plot cycles, and the last pixel is (159,119).
- R7: On the cycle after pixel (159,119), plot is low and done is high. Done stays high until a start is sampled, and x and y hold at 159 and 119 during that time.
- R8: A start sampled while a fill is running, including on its last pixel, is ignored: the pixel sequence and the fill length are unchanged.
- R9: A start sampled while done is high begins a new fill at (0,0), and done falls on the next cycle.
- R10: Plot is low whenever no fill is running, and plot and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that requests a new fill |
| px_x | output | 8 | Column of the current pixel |
| px_y | output | 7 | Row of the current pixel |
| px_colour | output | 3 | Colour of the current pixel |
| px_plot | output | 1 | High for each cycle in which a pixel is issued |
| fill_done | output | 1 | High once a fill has completed, until the next start |

## Verification
A start request can land on the same clock edge as the frame completes, that is, while pixel (159,119) is on the outputs. The bench forces this coincidence directly on the first fill. It then checks that the edge moves the block to the finished state, with done high and plot low, and does not start a new fill. Random start pulses also hit fills that are in progress, and arrive on the very first cycle that done is high. A reference model that counts pixels judges each cycle's coordinates, colour, strobe and the length of every fill.

// File: rtl/screen_fill_pkg.sv
package screen_fill_pkg;
  localparam int unsigned DEF_COLS = 160;
  localparam int unsigned DEF_ROWS = 120;
  localparam int unsigned DEF_CW   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fill_state_e;
endpackage

// File: rtl/screen_fill_dp.sv
module screen_fill_dp #(
  parameter int unsigned COLS = 160,
  parameter int unsigned ROWS = 120,
  parameter int unsigned CW   = 3,
  localparam int unsigned XW  = $clog2(COLS),
  localparam int unsigned YW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_clr,
  input  logic          cnt_inc,
  output logic [XW-1:0] col_q,
  output logic [YW-1:0] row_q,
  output logic [CW-1:0] colour,
  output logic          frame_end
);
  localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(ROWS - 1);

  logic col_wrap;
  assign col_wrap  = (col_q == X_LAST);
  assign frame_end = col_wrap && (row_q == Y_LAST);

  // column counter: inner loop
  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      col_q <= '0;
    end else if (cnt_inc) begin
      col_q <= col_wrap ? '0 : col_q + 1'b1;
    end
  end

  // row counter: outer loop
  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      row_q <= '0;
    end else if (cnt_inc && col_wrap) begin
      row_q <= row_q + 1'b1;
    end
  end

  // colour is column modulo 2**CW: the low bits, no divider
  assign colour = col_q[CW-1:0];

  a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !cnt_clr && !col_wrap) |=> (col_q == $past(col_q) + 1'b1) && (row_q == $past(row_q)));

  a_r4_col_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !cnt_clr && col_wrap) |=> (col_q == '0) && (row_q == $past(row_q) + 1'b1));

  a_r5_colour_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !cnt_clr && !col_wrap) |=> colour == CW'($past(colour) + 1'b1));

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (col_q == '0) && (row_q == '0));

  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    (col_q <= X_LAST) && (row_q <= Y_LAST));
endmodule

// File: rtl/screen_fill_ctrl.sv
module screen_fill_ctrl
  import screen_fill_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic frame_end,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic plot,
  output logic done
);
  fill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_clr = 1'b1;
        end
      end
      ST_RUN: begin
        if (frame_end) begin
          state_d = ST_FIN;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // outputs decoded straight from the state register
  assign plot = (state_q == ST_RUN);
  assign done = (state_q == ST_FIN);

  a_r8_run_holds: assert property (@(posedge clk) disable iff (rst)
    (plot && !frame_end) |=> plot);

  a_r7_finish: assert property (@(posedge clk) disable iff (rst)
    (plot && frame_end) |=> (done && !plot));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (plot && !done));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({plot, done}));

  a_r1_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!plot && !done));
endmodule

// File: rtl/screen_fill_top.sv
module screen_fill_top
  import screen_fill_pkg::*;
#(
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned CW   = DEF_CW,
  localparam int unsigned XW  = $clog2(COLS),
  localparam int unsigned YW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic [CW-1:0] px_colour,
  output logic          px_plot,
  output logic          fill_done
);
  logic cnt_clr, cnt_inc, frame_end;

  screen_fill_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .frame_end (frame_end),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .plot      (px_plot),
    .done      (fill_done)
  );

  screen_fill_dp #(.COLS(COLS), .ROWS(ROWS), .CW(CW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .col_q     (px_x),
    .row_q     (px_y),
    .colour    (px_colour),
    .frame_end (frame_end)
  );

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!px_plot && !fill_done && !start) |=> !px_plot);
endmodule

// File: tb/screen_fill_top_tb_top.sv
`timescale 1ns/1ps
module screen_fill_top_tb_top;
  localparam int COLS = 160;
  localparam int ROWS = 120;
  localparam int NCYC = 80000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] px_x;
  logic [6:0] px_y;
  logic [2:0] px_colour;
  logic       px_plot, fill_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  screen_fill_top dut_i (
    .clk(clk), .rst(rst), .start(start),
    .px_x(px_x), .px_y(px_y), .px_colour(px_colour),
    .px_plot(px_plot), .fill_done(fill_done)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_colour(input int x);
    return x % 8;
  endfunction

  // model: 0 idle, 1 running, 2 finished
  int  m_st = 0, mx = 0, my = 0;
  int  run_len = 0;
  bit  aborted = 1'b0;
  int  fills = 0;
  bit  did_reset = 1'b0;
  bit  forced_end = 1'b0;

  initial begin
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit s, r;
      @(negedge clk);
      // check current outputs against model
      if (cyc == 0) begin
        chk("R1 reset plot", px_plot == 1'b0, px_plot, 0);
        chk("R1 reset done", fill_done == 1'b0, fill_done, 0);
        chk("R1 reset x", px_x == 0, px_x, 0);
        chk("R1 reset y", px_y == 0, px_y, 0);
      end
      chk("R10 plot", px_plot == (m_st == 1), px_plot, (m_st == 1));
      chk("R7 done", fill_done == (m_st == 2), fill_done, (m_st == 2));
      if (m_st != 0) begin
        chk(m_st == 1 ? "R3/R4 x" : "R7 x hold", px_x == mx, px_x, mx);
        chk(m_st == 1 ? "R3/R4 y" : "R7 y hold", px_y == my, px_y, my);
      end
      if (m_st == 1)
        chk("R5 colour", px_colour == exp_colour(mx), px_colour, exp_colour(mx));
      // fill length at the falling plot edge
      if (m_st == 1) run_len++;
      else if (run_len != 0) begin
        if (!aborted) chk("R6 fill length", run_len == COLS*ROWS, run_len, COLS*ROWS);
        run_len = 0;
        aborted = 1'b0;
      end

      // choose stimulus for the next edge
      s = 1'b0;
      r = 1'b0;
      if (m_st == 1) begin
        if (!forced_end && mx == COLS-1 && my == ROWS-1) begin
          s = 1'b1;            // R8: start on the very last pixel
          forced_end = 1'b1;
        end else s = ($urandom_range(0, 499) == 0);  // R8: mid-fill start
        if (!did_reset && cyc >= 40000 && mx > 10) begin
          r = 1'b1;            // R1: reset in mid-fill
          did_reset = 1'b1;
          aborted = 1'b1;
        end
      end else begin
        s = ($urandom_range(0, 19) == 0);  // R2/R9
      end
      start = s;
      rst = r;

      // model next state
      if (r) begin
        m_st = 0; mx = 0; my = 0;
      end else if (m_st != 1 && s) begin
        m_st = 1; mx = 0; my = 0; fills++;
      end else if (m_st == 1) begin
        if (mx == COLS-1 && my == ROWS-1) m_st = 2;
        else if (mx == COLS-1) begin mx = 0; my++; end
        else mx++;
      end
      if (r) begin
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        chk("R1 mid reset plot", px_plot == 1'b0, px_plot, 0);
        chk("R1 mid reset x", px_x == 0, px_x, 0);
        chk("R1 mid reset y", px_y == 0, px_y, 0);
        run_len = 0;
        aborted = 1'b0;
      end
    end
    chk("R6 fills completed", fills >= 3, fills, 3);
    chk("R8 last-pixel start exercised", forced_end, forced_end, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule